// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two strap pins is wired on the board. A pin can be tied low, tied high, tied to the serial clock line or tied to the serial data line. From that it derives a four-bit slice of the bus address, plus one power-up default nibble and one pull-up enable nibble for each port group. The pin that drives the low half of the address field also governs port nibble 0 (bits 3:0). The other pin drives the high half and governs nibble 1 (bits 7:4).

The two pins arrive already synchronised. The pin class is judged afresh over every transmission on the bus, including traffic meant for other devices, so a board can re-strap the device without a power cycle. Inside a transmission, each pin is compared with SCL and SDA whenever `sampleStb` pulses. The new verdict only takes effect at STOP, so the address never changes in the middle of a transaction. Until a pin has been classified for the first time, the block reports it from its live level. A strap to either idle bus line therefore looks like a tie to the supply.

Top module: `addr_pin_decoder`

## Requirements
- R1: After reset and before a pin's first committed classification, the pin reads from its live level: high is treated as tied high and low as tied low.
- R2: The high pin sets `addrField[3:2]` with the codes clock-line 00, data-line 01, tied-low 10, tied-high 11.
- R3: The low pin sets `addrField[1:0]` with the codes tied-low 00, tied-high 01, clock-line 10, data-line 11.
- R4: A pin is classed as following SCL or SDA only if it equalled that line at every sample of the transmission. A single mismatch makes the class follow the pin's level at the last sample.
- R5: A line that held one level through all samples of a transmission cannot be chosen as the pin's class, even when the pin matched it. If the pin matches both lines, the clock line wins.
- R6: A new classification takes effect on the clock edge that carries `busStop`. While both pins are classified, the outputs stay unchanged in any cycle without `busStop`.
- R7: Each nibble of `ioDefault`, `outDefault` and `pullEn` is all zeros when its pin is classed tied-low, and all ones otherwise.
- R8: Every transmission with at least one sample re-classifies both pins, replacing the earlier result.
- R9: A `busStart` inside an open transmission (a repeated START) does not restart the matching: samples before and after it count together.
- R10: A transmission with no samples leaves the committed classification unchanged.
- R11: Reset returns both pins to the unclassified state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset |
| adrPinLo | input | 1 | Synchronised strap pin for the low address half and nibble 0 |
| adrPinHi | input | 1 | Synchronised strap pin for the high address half and nibble 1 |
| scl | input | 1 | Synchronised serial clock line level |
| sda | input | 1 | Synchronised serial data line level |
| busStart | input | 1 | One-cycle strobe for a START condition on the bus |
| busStop | input | 1 | One-cycle strobe for a STOP condition on the bus |
| sampleStb | input | 1 | One-cycle strobe marking a bus edge at which pins are compared |
| addrField | output | 4 | Derived address bits A3..A0 |
| ioDefault | output | 8 | Power-up default for the I/O port group |
| outDefault | output | 8 | Power-up default for the output port group |
| pullEn | output | 8 | Pull-up enables for the I/O port group |

## Verification
The bench walks both pins through all four wiring classes in a sequence of transmissions, so a stale or swapped code shows up as a wrong address half. It also covers cases where correlation must fail:
- A pin that follows the clock except at one sample must read as tied high. A decoder that tracked only the last sample would call it the clock line.
- A pin tied to a data line that never moved must also read as tied high. A decoder without the toggle test would call it the data line.

A repeated START placed so that the remaining samples show a flat data line exposes a decoder that wipes its tracking there. The bench also checks that the address holds its old value after the samples but before STOP, which catches an early commit. Finally, it checks that an empty transmission and a reset behave as stated: the first keeps the current classification, and the second drops back to the live-level reading.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    PC_GND = 2'd0,
    PC_VDD = 2'd1,
    PC_SCL = 2'd2,
    PC_SDA = 2'd3
  } pinClass_e;

  typedef struct packed {
    logic clear;
    logic sample;
    logic commit;
  } ctrlStb_t;

  // the upper pin's code is the lower pin's code with its top bit inverted
  localparam logic [1:0] UPPER_FLIP = 2'b10;
endpackage

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     busStart,
  input  logic     busStop,
  input  logic     sampleStb,
  output ctrlStb_t stb
);
  logic inTx;
  logic anySample;

  always_comb begin
    stb.clear  = busStart && !inTx;
    stb.sample = inTx && sampleStb && !busStop;
    stb.commit = inTx && busStop && anySample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inTx      <= 1'b0;
      anySample <= 1'b0;
    end else begin
      if (busStop) inTx <= 1'b0;
      else if (busStart) inTx <= 1'b1;
      if (stb.clear || busStop) anySample <= 1'b0;
      else if (stb.sample) anySample <= 1'b1;
    end
  end
endmodule

// File: rtl/apd_datapath.sv
module apd_datapath
  import apd_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  input  logic [NUM_PINS-1:0]     pinIn,
  input  logic                    scl,
  input  logic                    sda,
  output logic [2*NUM_PINS-1:0]   effCode,
  output logic [NUM_PINS-1:0]     clsValid
);
  // bit 0: line seen low, bit 1: line seen high
  logic [1:0] sclSeen;
  logic [1:0] sdaSeen;
  logic       sclToggled;
  logic       sdaToggled;

  assign sclToggled = &sclSeen;
  assign sdaToggled = &sdaSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSeen <= 2'b00;
      sdaSeen <= 2'b00;
    end else if (stb.clear) begin
      sclSeen <= 2'b00;
      sdaSeen <= 2'b00;
    end else if (stb.sample) begin
      sclSeen <= sclSeen | (scl ? 2'b10 : 2'b01);
      sdaSeen <= sdaSeen | (sda ? 2'b10 : 2'b01);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic      matchScl;
    logic      matchSda;
    logic      lastLvl;
    logic      validQ;
    pinClass_e clsQ;
    pinClass_e nextCls;

    always_comb begin
      if (matchScl && sclToggled)      nextCls = PC_SCL;
      else if (matchSda && sdaToggled) nextCls = PC_SDA;
      else if (lastLvl)                nextCls = PC_VDD;
      else                             nextCls = PC_GND;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchScl <= 1'b1;
        matchSda <= 1'b1;
        lastLvl  <= 1'b0;
        validQ   <= 1'b0;
        clsQ     <= PC_GND;
      end else begin
        if (stb.clear) begin
          matchScl <= 1'b1;
          matchSda <= 1'b1;
        end else if (stb.sample) begin
          matchScl <= matchScl && (pinIn[i] == scl);
          matchSda <= matchSda && (pinIn[i] == sda);
          lastLvl  <= pinIn[i];
        end
        if (stb.commit) begin
          clsQ   <= nextCls;
          validQ <= 1'b1;
        end
      end
    end

    assign effCode[2*i +: 2] = validQ ? clsQ : (pinIn[i] ? PC_VDD : PC_GND);
    assign clsValid[i]       = validQ;
  end
endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
  import apd_pkg::*;
#(
  parameter int NIBBLE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 adrPinLo,
  input  logic                 adrPinHi,
  input  logic                 scl,
  input  logic                 sda,
  input  logic                 busStart,
  input  logic                 busStop,
  input  logic                 sampleStb,
  output logic [3:0]           addrField,
  output logic [2*NIBBLE-1:0]  ioDefault,
  output logic [2*NIBBLE-1:0]  outDefault,
  output logic [2*NIBBLE-1:0]  pullEn
);
  localparam int NUM_PINS = 2;
  localparam int FIELD_W  = 2 * NUM_PINS;

  ctrlStb_t            stb;
  logic [FIELD_W-1:0]  effCode;
  logic [NUM_PINS-1:0] clsValid;

  apd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busStart  (busStart),
    .busStop   (busStop),
    .sampleStb (sampleStb),
    .stb       (stb)
  );

  apd_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pinIn    ({adrPinHi, adrPinLo}),
    .scl      (scl),
    .sda      (sda),
    .effCode  (effCode),
    .clsValid (clsValid)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_enc
    localparam logic [1:0] FLIP = (i == 0) ? 2'b00 : UPPER_FLIP;
    logic nibHigh;
    assign nibHigh = (effCode[2*i +: 2] != PC_GND);
    assign addrField[2*i +: 2]           = effCode[2*i +: 2] ^ FLIP;
    assign ioDefault[i*NIBBLE +: NIBBLE]  = {NIBBLE{nibHigh}};
    assign outDefault[i*NIBBLE +: NIBBLE] = {NIBBLE{nibHigh}};
    assign pullEn[i*NIBBLE +: NIBBLE]     = {NIBBLE{nibHigh}};
  end
endmodule

// File: rtl/apd_checker.sv
module apd_checker #(
  parameter int NIBBLE = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                adrPinLo,
  input logic                adrPinHi,
  input logic                busStop,
  input logic [3:0]          addrField,
  input logic [2*NIBBLE-1:0] ioDefault,
  input logic [2*NIBBLE-1:0] outDefault,
  input logic [2*NIBBLE-1:0] pullEn,
  input logic [1:0]          clsValid
);
  a_r1_live_lo: assert property (@(posedge clk) disable iff (!rstN)
    !clsValid[0] |-> addrField[1:0] == {1'b0, adrPinLo});

  a_r1_live_hi: assert property (@(posedge clk) disable iff (!rstN)
    !clsValid[1] |-> addrField[3:2] == {1'b1, adrPinHi});

  a_r6_hold_midtx: assert property (@(posedge clk) disable iff (!rstN)
    (&clsValid && !busStop) |=> $stable(addrField) && $stable(ioDefault));

  a_r7_gnd_lo: assert property (@(posedge clk) disable iff (!rstN)
    (addrField[1:0] == 2'b00) |-> ioDefault[NIBBLE-1:0] == '0);

  a_r7_gnd_hi: assert property (@(posedge clk) disable iff (!rstN)
    (addrField[3:2] == 2'b10) |-> ioDefault[2*NIBBLE-1:NIBBLE] == '0);

  a_r7_groups_agree: assert property (@(posedge clk) disable iff (!rstN)
    (outDefault == ioDefault) && (pullEn == ioDefault));

  a_r7_nibble_whole: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(ioDefault[NIBBLE-1:0]) == 0) || ($countones(ioDefault[NIBBLE-1:0]) == NIBBLE));

  a_r11_reset_unclassified: assert property (@(posedge clk)
    $rose(rstN) |-> clsValid == 2'b00);
endmodule

bind addr_pin_decoder apd_checker #(.NIBBLE(NIBBLE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .adrPinLo   (adrPinLo),
  .adrPinHi   (adrPinHi),
  .busStop    (busStop),
  .addrField  (addrField),
  .ioDefault  (ioDefault),
  .outDefault (outDefault),
  .pullEn     (pullEn),
  .clsValid   (clsValid)
);

// File: tb/sim_addr_pin_decoder.sv
`timescale 1ns/1ps
module sim_addr_pin_decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       adrPinLo = 1'b1, adrPinHi = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic       busStart = 1'b0, busStop = 1'b0, sampleStb = 1'b0;
  logic [3:0] addrField;
  logic [7:0] ioDefault, outDefault, pullEn;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_pin_decoder u0 (
    .clk(clk), .rstN(rstN), .adrPinLo(adrPinLo), .adrPinHi(adrPinHi),
    .scl(scl), .sda(sda), .busStart(busStart), .busStop(busStop),
    .sampleStb(sampleStb), .addrField(addrField), .ioDefault(ioDefault),
    .outDefault(outDefault), .pullEn(pullEn)
  );

  // bench wiring modes: 0 tied low, 1 tied high, 2 on clock line, 3 on data line
  // entry: {modeLo[1:0], modeHi[1:0], expected addrField[3:0]}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 2'd0, 4'b1000},
    {2'd1, 2'd1, 4'b1101},
    {2'd2, 2'd2, 4'b0010},
    {2'd3, 2'd3, 4'b0111},
    {2'd2, 2'd3, 4'b0110},
    {2'd3, 2'd0, 4'b1011},
    {2'd0, 2'd2, 4'b0000},
    {2'd1, 2'd3, 4'b0101}
  };

  function automatic logic pinFor(input logic [1:0] m, input logic c, input logic d);
    case (m)
      2'd0: pinFor = 1'b0;
      2'd1: pinFor = 1'b1;
      2'd2: pinFor = c;
      default: pinFor = d;
    endcase
  endfunction

  function automatic logic [7:0] expNib(input logic loHigh, input logic hiHigh);
    expNib = {{4{hiHigh}}, {4{loHigh}}};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag, input logic [3:0] expA, input logic [7:0] expD);
    chk({tag, " addr"}, {4'h0, addrField}, {4'h0, expA});
    chk({tag, " R7 io"}, ioDefault, expD);
    chk({tag, " R7 out"}, outDefault, expD);
    chk({tag, " R7 pull"}, pullEn, expD);
  endtask

  task automatic drive(input logic [1:0] mLo, input logic [1:0] mHi);
    adrPinLo = pinFor(mLo, scl, sda);
    adrPinHi = pinFor(mHi, scl, sda);
  endtask

  task automatic txStart();
    @(negedge clk) busStart = 1'b1;
    @(negedge clk) busStart = 1'b0;
  endtask

  task automatic txSample(input logic [1:0] mLo, input logic [1:0] mHi, input int k,
                          input bit flipLo, input bit sdaFlat);
    @(negedge clk);
    scl = k[0];
    sda = sdaFlat ? 1'b1 : k[1];
    drive(mLo, mHi);
    if (flipLo) adrPinLo = ~adrPinLo;
    sampleStb = 1'b1;
    @(negedge clk) sampleStb = 1'b0;
  endtask

  task automatic txStop(input logic [1:0] mLo, input logic [1:0] mHi);
    @(negedge clk);
    scl = 1'b1; sda = 1'b1;
    drive(mLo, mHi);
    busStop = 1'b1;
    @(negedge clk) busStop = 1'b0;
  endtask

  task automatic fullTx(input logic [1:0] mLo, input logic [1:0] mHi);
    txStart();
    for (int k = 0; k < 4; k++) txSample(mLo, mHi, k, 1'b0, 1'b0);
    txStop(mLo, mHi);
  endtask

  initial begin
    #200000;
    if (!done) begin
      applied++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1, R11: unclassified pins high read as tied high
    verify("R1 R11 reset high", 4'b1101, 8'hff);
    adrPinLo = 1'b0; adrPinHi = 1'b0;
    @(negedge clk);
    verify("R1 reset low", 4'b1000, 8'h00);

    // R2 R3 R8: table of wiring combinations, one transmission each
    for (int v = 0; v < 8; v++) begin
      logic [1:0] mLo, mHi;
      mLo = VEC[v][7:6];
      mHi = VEC[v][5:4];
      fullTx(mLo, mHi);
      verify($sformatf("R2 R3 R8 vec%0d", v), VEC[v][3:0], expNib(mLo != 0, mHi != 0));
    end

    // R6: hold old value until STOP (last table entry gave 0101)
    txStart();
    for (int k = 0; k < 4; k++) txSample(2'd2, 2'd2, k, 1'b0, 1'b0);
    @(negedge clk);
    verify("R6 before stop", 4'b0101, 8'hff);
    txStop(2'd2, 2'd2);
    verify("R6 after stop", 4'b0010, 8'hff);

    // R4: low pin follows clock except at one sample -> last level high
    txStart();
    for (int k = 0; k < 4; k++) txSample(2'd2, 2'd1, k, k == 1, 1'b0);
    txStop(2'd2, 2'd1);
    verify("R4 one mismatch", 4'b1101, 8'hff);

    // R5: high pin on a data line that never moved -> tied high
    txStart();
    for (int k = 0; k < 4; k++) txSample(2'd0, 2'd3, k, 1'b0, 1'b1);
    txStop(2'd0, 2'd3);
    verify("R5 flat line", 4'b1100, 8'hf0);

    // R9: repeated START after two samples does not restart matching
    txStart();
    for (int k = 0; k < 2; k++) txSample(2'd0, 2'd3, k, 1'b0, 1'b0);
    txStart();
    for (int k = 2; k < 4; k++) txSample(2'd0, 2'd3, k, 1'b0, 1'b0);
    txStop(2'd0, 2'd3);
    verify("R9 repeated start", 4'b0100, 8'hf0);

    // R10: empty transmission with pins moved keeps classification
    adrPinLo = 1'b1; adrPinHi = 1'b1;
    txStart();
    txStop(2'd1, 2'd1);
    verify("R10 empty tx", 4'b0100, 8'hf0);

    // R11: reset drops back to live-level reading
    @(negedge clk) rstN = 1'b0;
    adrPinLo = 1'b0; adrPinHi = 1'b1;
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    verify("R11 after reset", 4'b1100, 8'hf0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule